// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block brings an SDRAM device from power-up to a usable state with no processor involved. After reset it holds the clock enable low and drives idle bus cycles. A single start pulse then sets off a fixed list of steps. The first step raises the clock enable and waits a long settling time. The remaining steps precharge all banks, load the extended mode register on the device types that have one, load the mode register with DLL reset, precharge again, refresh once, and load the mode register a second time without DLL reset. Each step is followed by its own wait in clock cycles.

The memory kind, the CAS latency, the PHY phase count and the three wait lengths are parameters. From these the block derives the burst length and the mode word. It then raises a sticky done flag, and the controller that owns the bus after that point can begin normal traffic. The command outputs are active low, as on the device pins.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and afterwards until start is sampled high, cke is 0, {cs_n,ras_n,cas_n,we_n} is 4'b1111, addr and ba are 0 and done is 0.
- R2: On {cs_n,ras_n,cas_n,we_n}, precharge-all is 4'b0010, mode-register load is 4'b0000, auto-refresh is 4'b0001 and idle is 4'b1111. Every idle cycle drives addr and ba to 0.
- R3: cke goes to 1 in the cycle after the edge that samples start, and it stays 1 until reset. No command is issued while cke is 0. The first command appears CKE_WAIT+1 cycles after cke rises.
- R4: Precharge-all carries addr 0x400 (only bit 10 set) and ba 0.
- R5: Each command lasts exactly one cycle. A step with wait W is followed by exactly W idle cycles before the next command, so W=0 gives back-to-back commands.
- R6: For MEM_KIND 0 (SDR), the commands after the cke step are, in order: precharge-all; mode load with DLL reset, wait MODE_WAIT; precharge-all; auto-refresh, wait REF_WAIT; mode load without DLL reset, wait MODE_WAIT.
- R7: For MEM_KIND 1 (DDR) and 3 (DDR2), an extended mode load with addr EXT_MODE, ba 1 and zero wait follows the first precharge-all. The rest of the order matches R6.
- R8: For MEM_KIND 2 (LPDDR), the order is the same as in R7, but the extended mode load uses ba 2.
- R9: The mode word is log2(BL) + (CAS_LAT << 4). BL is PHASES for SDR and 2*PHASES for the other kinds. The first mode load has DLL_RESET added (default 0x100, or 0 for SDR), and the last mode load uses the plain word. Both mode loads use ba 0.
- R10: done rises one cycle after the final wait expires and stays high until reset. From then on the bus is idle and cke stays 1.
- R11: A start pulse that arrives while the sequence runs, or after done, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the sequence when sampled high in the idle state |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus; carries the mode words and the A10 flag for precharge-all |
| ba | output | BA_W | Bank address |
| done | output | 1 | High once the sequence has finished |

## Verification
A step index that is off by one would show on the very next command slot. The port would carry a wrong command code, a wrong bank or a wrong mode word, or a command would be dropped or repeated. A wrong wait count moves every later command and the done edge by the same number of cycles, so it is caught at the first command after that wait. The bench compares the whole output vector of four configurations against a trace it builds itself, on every cycle from start to well past done. Any shift, any extra command or any stray activity after done is therefore reported in the cycle where it first appears.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

   typedef enum logic [1:0] {
      MEM_SDR   = 2'd0,
      MEM_DDR   = 2'd1,
      MEM_LPDDR = 2'd2,
      MEM_DDR2  = 2'd3
   } mem_kind_e;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MODE = 4'b0000,
      CMD_REFR = 4'b0001,
      CMD_PALL = 4'b0010,
      CMD_IDLE = 4'b1111
   } bus_cmd_e;

   typedef enum logic [2:0] {
      ADDR_ZERO,
      ADDR_PALL,
      ADDR_EXT,
      ADDR_MODE_DLL,
      ADDR_MODE
   } addr_sel_e;

   typedef enum logic [1:0] {
      HOLD_NONE,
      HOLD_CKE,
      HOLD_MODE,
      HOLD_REFR
   } hold_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_FIN
   } run_state_e;

   typedef struct packed {
      bus_cmd_e  cmd;
      logic      raise_cke;
      logic [1:0] bank;
      addr_sel_e asel;
      hold_sel_e hsel;
   } boot_step_t;

   localparam boot_step_t STEP_BLANK = '{cmd: CMD_IDLE, raise_cke: 1'b0, bank: 2'd0,
                                         asel: ADDR_ZERO, hsel: HOLD_NONE};

   localparam int STEP_IDX_W = 3;

endpackage

// File: rtl/sdram_boot_steps.sv
module sdram_boot_steps
   import sdram_boot_pkg::*;
#(
   parameter int MEM_KIND = 1
) (
   input  logic [STEP_IDX_W-1:0] idx,
   output boot_step_t            step
);
   localparam bit         HAS_EXT  = (MEM_KIND != 0);
   localparam logic [1:0] EXT_BANK = (MEM_KIND == 2) ? 2'd2 : 2'd1;

   if (HAS_EXT) begin : g_ext
      always_comb begin
         step = STEP_BLANK;
         case (idx)
            3'd0: step = '{CMD_IDLE, 1'b1, 2'd0,     ADDR_ZERO,     HOLD_CKE};
            3'd1: step = '{CMD_PALL, 1'b0, 2'd0,     ADDR_PALL,     HOLD_NONE};
            3'd2: step = '{CMD_MODE, 1'b0, EXT_BANK, ADDR_EXT,      HOLD_NONE};
            3'd3: step = '{CMD_MODE, 1'b0, 2'd0,     ADDR_MODE_DLL, HOLD_MODE};
            3'd4: step = '{CMD_PALL, 1'b0, 2'd0,     ADDR_PALL,     HOLD_NONE};
            3'd5: step = '{CMD_REFR, 1'b0, 2'd0,     ADDR_ZERO,     HOLD_REFR};
            3'd6: step = '{CMD_MODE, 1'b0, 2'd0,     ADDR_MODE,     HOLD_MODE};
            default: step = STEP_BLANK;
         endcase
      end
   end else begin : g_plain
      always_comb begin
         step = STEP_BLANK;
         case (idx)
            3'd0: step = '{CMD_IDLE, 1'b1, 2'd0, ADDR_ZERO,     HOLD_CKE};
            3'd1: step = '{CMD_PALL, 1'b0, 2'd0, ADDR_PALL,     HOLD_NONE};
            3'd2: step = '{CMD_MODE, 1'b0, 2'd0, ADDR_MODE_DLL, HOLD_MODE};
            3'd3: step = '{CMD_PALL, 1'b0, 2'd0, ADDR_PALL,     HOLD_NONE};
            3'd4: step = '{CMD_REFR, 1'b0, 2'd0, ADDR_ZERO,     HOLD_REFR};
            3'd5: step = '{CMD_MODE, 1'b0, 2'd0, ADDR_MODE,     HOLD_MODE};
            default: step = STEP_BLANK;
         endcase
      end
   end
endmodule

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer
   import sdram_boot_pkg::*;
#(
   parameter int CNT_W     = 11,
   parameter int CKE_WAIT  = 2000,
   parameter int MODE_WAIT = 200,
   parameter int REF_WAIT  = 4
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      load,
   input  hold_sel_e sel,
   output logic      expired
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      case (sel)
         HOLD_CKE:  load_val = CNT_W'(CKE_WAIT);
         HOLD_MODE: load_val = CNT_W'(MODE_WAIT);
         HOLD_REFR: load_val = CNT_W'(REF_WAIT);
         default:   load_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_boot_drive.sv
module sdram_boot_drive
   import sdram_boot_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BA_W      = 2,
   parameter int EXT_WORD  = 0,
   parameter int MODE_WORD = 0,
   parameter int DLL_WORD  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue,
   input  logic              finish,
   input  boot_step_t        step,
   output logic              cke,
   output logic [3:0]        cmd_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              done
);
   localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << 10;

   logic [ADDR_W-1:0] addr_mux;

   always_comb begin
      case (step.asel)
         ADDR_PALL:     addr_mux = PALL_ADDR;
         ADDR_EXT:      addr_mux = ADDR_W'(EXT_WORD);
         ADDR_MODE_DLL: addr_mux = ADDR_W'(MODE_WORD + DLL_WORD);
         ADDR_MODE:     addr_mux = ADDR_W'(MODE_WORD);
         default:       addr_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cke   <= 1'b0;
         cmd_n <= CMD_IDLE;
         addr  <= '0;
         ba    <= '0;
         done  <= 1'b0;
      end else begin
         if (issue) begin
            cmd_n <= step.cmd;
            addr  <= addr_mux;
            ba    <= BA_W'(step.bank);
            if (step.raise_cke) cke <= 1'b1;
         end else begin
            cmd_n <= CMD_IDLE;
            addr  <= '0;
            ba    <= '0;
         end
         if (finish) done <= 1'b1;
      end
   end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int MEM_KIND  = 1,
   parameter int CAS_LAT   = 3,
   parameter int PHASES    = 1,
   parameter int ADDR_W    = 13,
   parameter int BA_W      = 2,
   parameter int CKE_WAIT  = 2000,
   parameter int MODE_WAIT = 200,
   parameter int REF_WAIT  = 4,
   parameter int EXT_MODE  = 0,
   parameter int DLL_RESET = (MEM_KIND == 0) ? 0 : 'h100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              done
);
   localparam int BURST_LEN = (MEM_KIND == 0) ? PHASES : 2 * PHASES;
   localparam int MODE_WORD = $clog2(BURST_LEN) + (CAS_LAT << 4);
   localparam int N_STEPS   = (MEM_KIND == 0) ? 6 : 7;
   localparam int MAX_A     = (CKE_WAIT > MODE_WAIT) ? CKE_WAIT : MODE_WAIT;
   localparam int MAX_WAIT  = (MAX_A > REF_WAIT) ? MAX_A : REF_WAIT;
   localparam int CNT_W     = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

   if (MEM_KIND < 0 || MEM_KIND > 3) begin : g_bad_kind
      $error("MEM_KIND must be 0..3");
   end
   if (PHASES < 1 || (PHASES & (PHASES - 1)) != 0) begin : g_bad_phases
      $error("PHASES must be a power of two");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must reach bit 10");
   end
   if (BA_W < 2) begin : g_bad_ba
      $error("BA_W must be at least 2");
   end
   if (MODE_WORD + DLL_RESET >= (1 << ADDR_W) || EXT_MODE >= (1 << ADDR_W)) begin : g_bad_word
      $error("mode words do not fit the address bus");
   end

   run_state_e              state_q;
   logic [STEP_IDX_W-1:0]   idx_q;
   logic [STEP_IDX_W-1:0]   look_idx;
   logic                    at_last;
   logic                    expired;
   logic                    issue;
   logic                    finish;
   boot_step_t              step;
   logic [3:0]              cmd_n;

   assign look_idx = (state_q == ST_IDLE) ? '0 : idx_q + 1'b1;
   assign at_last  = (idx_q == STEP_IDX_W'(N_STEPS - 1));
   assign issue    = ((state_q == ST_IDLE) && start) ||
                     ((state_q == ST_RUN) && expired && !at_last);
   assign finish   = (state_q == ST_RUN) && expired && at_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         if (issue) idx_q <= look_idx;
         if ((state_q == ST_IDLE) && start) state_q <= ST_RUN;
         else if (finish)                   state_q <= ST_FIN;
      end
   end

   sdram_boot_steps #(.MEM_KIND(MEM_KIND)) u_steps (
      .idx  (look_idx),
      .step (step)
   );

   sdram_boot_timer #(
      .CNT_W     (CNT_W),
      .CKE_WAIT  (CKE_WAIT),
      .MODE_WAIT (MODE_WAIT),
      .REF_WAIT  (REF_WAIT)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (issue),
      .sel     (step.hsel),
      .expired (expired)
   );

   sdram_boot_drive #(
      .ADDR_W    (ADDR_W),
      .BA_W      (BA_W),
      .EXT_WORD  (EXT_MODE),
      .MODE_WORD (MODE_WORD),
      .DLL_WORD  (DLL_RESET)
   ) u_drive (
      .clk    (clk),
      .rst    (rst),
      .issue  (issue),
      .finish (finish),
      .step   (step),
      .cke    (cke),
      .cmd_n  (cmd_n),
      .addr   (addr),
      .ba     (ba),
      .done   (done)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd_n;
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic              done
);
   localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << 10;

   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> (ras_n && cas_n && we_n && addr == '0 && ba == '0)); // R2
   AST_CMD_HAS_RAS: assert property (@(posedge clk) disable iff (rst)
      !cs_n |-> !ras_n); // R2
   AST_NO_CMD_COLD: assert property (@(posedge clk) disable iff (rst)
      !cke |-> cs_n); // R3
   AST_CKE_STAYS: assert property (@(posedge clk) disable iff (rst)
      cke |=> cke); // R3
   AST_PALL_A10: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !ras_n && cas_n && !we_n) |-> (addr == A10 && ba == '0)); // R4
   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      !cs_n |=> (cs_n || !$stable({ras_n, cas_n, we_n, addr, ba}))); // R5
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      done |=> done); // R10
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      done |-> (cs_n && cke)); // R10
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .cke   (cke),
   .cs_n  (cs_n),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .addr  (addr),
   .ba    (ba),
   .done  (done)
);

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;
   localparam int NCFG = 4;
   localparam int AW   = 13;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   always #4 clk = ~clk;

   logic [NCFG-1:0] cke_v, cs_v, ras_v, cas_v, we_v, done_v;
   logic [AW-1:0]   addr_v [NCFG];
   logic [1:0]      ba_v   [NCFG];

   function automatic int cfg_phases(int g);
      return (g == 0) ? 2 : (g == 1) ? 1 : (g == 2) ? 2 : 4;
   endfunction
   function automatic int cfg_cl(int g);
      return g + 2;
   endfunction
   function automatic int cfg_cke(int g);
      return 10 + g;
   endfunction
   localparam int MW = 5;
   localparam int RW = 2;

   for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      sdram_boot_seq #(
         .MEM_KIND  (g),
         .CAS_LAT   (cfg_cl(g)),
         .PHASES    (cfg_phases(g)),
         .ADDR_W    (AW),
         .BA_W      (2),
         .CKE_WAIT  (cfg_cke(g)),
         .MODE_WAIT (MW),
         .REF_WAIT  (RW),
         .EXT_MODE  ('h20 + g)
      ) uut (
         .clk   (clk),
         .rst   (rst),
         .start (start),
         .cke   (cke_v[g]),
         .cs_n  (cs_v[g]),
         .ras_n (ras_v[g]),
         .cas_n (cas_v[g]),
         .we_n  (we_v[g]),
         .addr  (addr_v[g]),
         .ba    (ba_v[g]),
         .done  (done_v[g])
      );
   end

   int n_total = 0;
   int n_fail  = 0;

   // expected step list per configuration
   int st_n    [NCFG];
   int st_time [NCFG][8];
   int st_cmd  [NCFG][8];
   int st_addr [NCFG][8];
   int st_ba   [NCFG][8];
   string st_tag [NCFG][8];
   int done_at [NCFG];

   task automatic add_step(int g, int cmd, int a, int b, int w, string tag, inout int t);
      st_time[g][st_n[g]] = t;
      st_cmd[g][st_n[g]]  = cmd;
      st_addr[g][st_n[g]] = a;
      st_ba[g][st_n[g]]   = b;
      st_tag[g][st_n[g]]  = tag;
      st_n[g]++;
      t = t + w + 1;
   endtask

   task automatic build_expect();
      for (int g = 0; g < NCFG; g++) begin
         int t = 0;
         int bl  = (g == 0) ? cfg_phases(g) : 2 * cfg_phases(g);
         int mw  = $clog2(bl) + (cfg_cl(g) << 4);
         int dll = (g == 0) ? 0 : 'h100;
         string otag = (g == 0) ? "R6" : "R7";
         st_n[g] = 0;
         add_step(g, 'hF, 0, 0, cfg_cke(g), "R3", t);
         add_step(g, 'h2, 'h400, 0, 0, "R4", t);
         if (g != 0) add_step(g, 'h0, 'h20 + g, (g == 2) ? 2 : 1, 0, (g == 2) ? "R8" : "R7", t);
         add_step(g, 'h0, mw + dll, 0, MW, "R9", t);
         add_step(g, 'h2, 'h400, 0, 0, otag, t);
         add_step(g, 'h1, 0, 0, RW, otag, t);
         add_step(g, 'h0, mw, 0, MW, "R9", t);
         done_at[g] = t;
      end
   endtask

   task automatic check_cfg(int g, int t, int ex_cke, int ex_cmd, int ex_a, int ex_b,
                            int ex_done, string tag);
      int got_cmd = {cs_v[g], ras_v[g], cas_v[g], we_v[g]};
      n_total++;
      if (cke_v[g] !== ex_cke[0] || got_cmd != ex_cmd || int'(addr_v[g]) != ex_a ||
          int'(ba_v[g]) != ex_b || done_v[g] !== ex_done[0]) begin
         n_fail++;
         $display("FAIL %s cfg%0d t=%0d: got cke=%0d cmd=%h addr=%h ba=%0d done=%0d, exp cke=%0d cmd=%h addr=%h ba=%0d done=%0d",
                  tag, g, t, cke_v[g], got_cmd, addr_v[g], ba_v[g], done_v[g],
                  ex_cke, ex_cmd, ex_a, ex_b, ex_done);
      end
   endtask

   task automatic check_at(int t, bit pulsed);
      for (int g = 0; g < NCFG; g++) begin
         int ecmd = 'hF;
         int ea = 0;
         int eb = 0;
         string tag = "R5";
         for (int i = 0; i < st_n[g]; i++) begin
            if (st_time[g][i] == t) begin
               ecmd = st_cmd[g][i];
               ea   = st_addr[g][i];
               eb   = st_ba[g][i];
               tag  = st_tag[g][i];
            end
         end
         if (t >= done_at[g]) tag = "R10";
         if (pulsed) tag = "R11";
         else if (ecmd == 'hF && tag == "R5") tag = "R2";
         check_cfg(g, t, 1, ecmd, ea, eb, (t >= done_at[g]) ? 1 : 0, tag);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      n_total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin : main
      bit pulsed;
      build_expect();
      // R1: idle under reset and after it until start
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int g = 0; g < NCFG; g++) check_cfg(g, -1, 0, 'hF, 0, 0, 0, "R1");
      rst = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         for (int g = 0; g < NCFG; g++) check_cfg(g, -1, 0, 'hF, 0, 0, 0, "R1");
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      pulsed = 1'b0;
      for (int t = 0; t < 100; t++) begin
         check_at(t, pulsed && (t == 6 || t >= 81));
         // R11: extra start pulses mid-run and after done
         start = (t == 5 || t == 80);
         if (t == 5 || t == 80) pulsed = 1'b1;
         @(negedge clk);
      end
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule